// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block walks an attached panel controller through its power-up and power-down command lists. It sits in front of a separate serial writer that frames each command and its data bytes. The sequencer presents one step at a time on a request port: a command byte, the number of data bytes that follow (zero, one or two), and a 16-bit data value. The step stays on the port until the writer reports completion. Some steps are followed by a fixed wait of a configurable number of milliseconds. The wait length is derived from the system clock frequency parameter.

A pulse on `start_on` runs bring-up if the panel is off. A pulse on `start_off` runs shutdown if the panel is on. Bring-up opens with three bare zero commands, each followed by a wait. A writer error on any of these three ends the attempt immediately. After that, writer errors do not stop the list: they are collected and reported once the list has finished. `busy` covers the whole run. `active` records whether the panel was last brought up, and `error` reports how the most recent bring-up ended.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset `busy`, `active`, `error` and `req_valid` are all 0.
- R2: Bring-up starts with three requests of command 0x00 with `req_nbytes`=0. After each of these is completed, `req_valid` stays low for exactly WAIT_MS*CLK_HZ/1000 cycles before the next request.
- R3: If `wr_err` is high with `wr_done` on any of those three opening requests, the run stops at once. No further request is made, `busy` and `active` are 0, and `error` is 1.
- R4: Bring-up then issues, in this order (command/nbytes/data): B0/1/0017, BC/1/0080, 3B/1/0000, B0/1/0016, B8/2/FFF9, 11/0, 29/0. With one data byte the value sits in `req_data[7:0]`. Afterwards `active` is 1 and `busy` is 0.
- R5: A writer error on any bring-up step after the opening three does not stop the list. When the list completes, `active` is 1 and `error` is 1.
- R6: Shutdown issues 28/0, B8/2/8002, 10/0, B0/1/0000 in that order, then clears `active`. Writer errors during shutdown do not stop it and leave `error` at 0.
- R7: `start_on` while `active` is 1, and `start_off` while `active` is 0, are ignored: `busy` stays 0.
- R8: Start pulses that arrive while `busy` is 1 are ignored. The running list finishes unchanged.
- R9: `busy` is 1 from the cycle after an accepted start until the list ends. A request holds `req_valid` and its fields steady until `wr_done` is seen, and each `wr_done` moves on by exactly one step.
- R10: Accepting either start clears `error` in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_on | input | 1 | Pulse: request bring-up |
| start_off | input | 1 | Pulse: request shutdown |
| req_valid | output | 1 | A step is presented to the writer |
| req_cmd | output | 8 | Command byte of the current step |
| req_nbytes | output | 2 | Number of data bytes (0 to 2) |
| req_data | output | 16 | Data value, high byte sent first when two bytes |
| wr_done | input | 1 | Writer finished the presented step |
| wr_err | input | 1 | Writer failed that step (valid with wr_done) |
| active | output | 1 | Panel has been brought up |
| busy | output | 1 | A list is running |
| error | output | 1 | Last bring-up aborted or collected an error |

## Verification
The assertions assume that the writer raises `wr_done` only while `req_valid` is high, and for a single cycle per step. They also assume that `wr_err` carries meaning only in that cycle. The bench writer model drives `wr_done` after a fixed latency while a request is up, and always drops it on the following cycle. Start pulses are one cycle wide and are driven from the inactive edge. Error injection targets one chosen step of a run, and covers both an opening step and a later one.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

    localparam int STEP_AW = 4;
    localparam logic [STEP_AW-1:0] ON_BASE  = 4'd0;
    localparam logic [STEP_AW-1:0] OFF_BASE = 4'd10;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [1:0]  nbytes;
        logic [15:0] payload;
        logic        pause;   // wait after completion
        logic        fatal;   // an error here aborts the run
        logic        last;    // final step of its list
    } step_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_st_e;

    function automatic step_t mk_step(input logic [7:0] c, input logic [1:0] n,
                                      input logic [15:0] v, input logic p,
                                      input logic f, input logic l);
        step_t s;
        s.cmd     = c;
        s.nbytes  = n;
        s.payload = v;
        s.pause   = p;
        s.fatal   = f;
        s.last    = l;
        return s;
    endfunction

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
    import panel_seq_pkg::*;
#(
    parameter int AW = STEP_AW
) (
    input  logic [AW-1:0] idx,
    output step_t         step
);
    always_comb begin
        unique case (idx)
            // bring-up: opening zero commands, each followed by a wait
            4'd0:    step = mk_step(8'h00, 2'd0, 16'h0000, 1'b1, 1'b1, 1'b0);
            4'd1:    step = mk_step(8'h00, 2'd0, 16'h0000, 1'b1, 1'b1, 1'b0);
            4'd2:    step = mk_step(8'h00, 2'd0, 16'h0000, 1'b1, 1'b1, 1'b0);
            4'd3:    step = mk_step(8'hB0, 2'd1, 16'h0017, 1'b0, 1'b0, 1'b0);
            4'd4:    step = mk_step(8'hBC, 2'd1, 16'h0080, 1'b0, 1'b0, 1'b0);
            4'd5:    step = mk_step(8'h3B, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b0);
            4'd6:    step = mk_step(8'hB0, 2'd1, 16'h0016, 1'b0, 1'b0, 1'b0);
            4'd7:    step = mk_step(8'hB8, 2'd2, 16'hFFF9, 1'b0, 1'b0, 1'b0);
            4'd8:    step = mk_step(8'h11, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0);
            4'd9:    step = mk_step(8'h29, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1);
            // shutdown
            4'd10:   step = mk_step(8'h28, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0);
            4'd11:   step = mk_step(8'hB8, 2'd2, 16'h8002, 1'b0, 1'b0, 1'b0);
            4'd12:   step = mk_step(8'h10, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0);
            4'd13:   step = mk_step(8'hB0, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b1);
            default: step = mk_step(8'h00, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b1);
        endcase
    end
endmodule

// File: rtl/panel_seq_timer.sv
module panel_seq_timer #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int WAIT_MS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int WAIT_CYC = (CLK_HZ / 1000) * WAIT_MS;
    localparam int CW       = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == LAST_CNT);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || expired) cnt_d = '0;
        else                 cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
    import panel_seq_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int WAIT_MS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_on,
    input  logic        start_off,
    output logic        req_valid,
    output logic [7:0]  req_cmd,
    output logic [1:0]  req_nbytes,
    output logic [15:0] req_data,
    input  logic        wr_done,
    input  logic        wr_err,
    output logic        active,
    output logic        busy,
    output logic        error
);
    localparam int AW = STEP_AW;
    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        seq_st_e       st;
        logic [AW-1:0] idx;
        logic          on_seq;
        logic          acc_err;
        logic          active;
        logic          error;
    } ctl_t;

    ctl_t  d, q;
    step_t cur_step;
    logic  tmr_run, tmr_exp, step_end, acc_n;

    panel_seq_rom #(.AW(AW)) u_rom (
        .idx  (q.idx),
        .step (cur_step)
    );

    panel_seq_timer #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    always_comb begin
        d        = q;
        tmr_run  = (q.st == ST_WAIT);
        step_end = 1'b0;
        acc_n    = q.acc_err | (wr_err & q.on_seq);
        unique case (q.st)
            ST_IDLE: begin
                if (start_on && !q.active) begin
                    d.st      = ST_REQ;
                    d.idx     = ON_BASE;
                    d.on_seq  = 1'b1;
                    d.acc_err = 1'b0;
                    d.error   = 1'b0;
                end else if (start_off && q.active) begin
                    d.st      = ST_REQ;
                    d.idx     = OFF_BASE;
                    d.on_seq  = 1'b0;
                    d.acc_err = 1'b0;
                    d.error   = 1'b0;
                end
            end
            ST_REQ: begin
                if (wr_done) begin
                    if (wr_err && cur_step.fatal) begin
                        d.st    = ST_IDLE;
                        d.error = 1'b1;
                    end else begin
                        d.acc_err = acc_n;
                        if (cur_step.pause) d.st = ST_WAIT;
                        else                step_end = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_exp) step_end = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
        if (step_end) begin
            if (cur_step.last) begin
                d.st     = ST_IDLE;
                d.active = q.on_seq;
                d.error  = d.acc_err;
            end else begin
                d.st  = ST_REQ;
                d.idx = q.idx + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.idx     <= '0;
            q.on_seq  <= 1'b0;
            q.acc_err <= 1'b0;
            q.active  <= 1'b0;
            q.error   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_valid  = (q.st == ST_REQ);
    assign req_cmd    = cur_step.cmd;
    assign req_nbytes = cur_step.nbytes;
    assign req_data   = cur_step.payload;
    assign busy       = (q.st != ST_IDLE);
    assign active     = q.active;
    assign error      = q.error;

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !wr_done |=> req_valid && $stable(req_cmd)
                                  && $stable(req_nbytes) && $stable(req_data));

    assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    assert_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && wr_done && wr_err && cur_step.fatal |=> !busy && error && !active);

    assert_ign_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && active && start_on && !start_off |=> !busy);

    assert_ign_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !active && start_off && !start_on |=> !busy);

    assert_active_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> $past(busy) && !busy);

    assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start_on && !active |=> busy && !error);
endmodule

// File: tb/sim_panel_pwr_seq.sv
`timescale 1ns/1ps
module sim_panel_pwr_seq;
    localparam int CLK_HZ   = 20_000;
    localparam int WAIT_CYC = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_on = 1'b0, start_off = 1'b0;
    logic wr_done = 1'b0, wr_err = 1'b0;
    logic req_valid, active, busy, error;
    logic [7:0]  req_cmd;
    logic [1:0]  req_nbytes;
    logic [15:0] req_data;

    always #2 clk = ~clk;

    panel_pwr_seq #(.CLK_HZ(CLK_HZ), .WAIT_MS(1)) u0 (
        .clk(clk), .rst_n(rst_n), .start_on(start_on), .start_off(start_off),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_nbytes(req_nbytes),
        .req_data(req_data), .wr_done(wr_done), .wr_err(wr_err),
        .active(active), .busy(busy), .error(error)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model
    typedef struct {int cmd; int nb; int val; bit pause; bit fatal;} exp_t;
    exp_t mq[$];
    bit m_busy, m_active, m_error, m_on, m_acc;
    int inj = -1;
    int tx_n = 0;
    int gap = 0, exp_gap = 0, lat = 0;
    bit gap_armed = 0;

    function automatic void push(int c, int n, int v, bit p, bit f);
        exp_t e;
        e.cmd = c; e.nb = n; e.val = v; e.pause = p; e.fatal = f;
        mq.push_back(e);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_active = 0; m_error = 0; m_on = 0; m_acc = 0;
            mq.delete();
        end else if (!m_busy) begin
            if (start_on && !m_active) begin
                m_busy = 1; m_on = 1; m_acc = 0; m_error = 0;
                for (int i = 0; i < 3; i++) push(8'h00, 0, 0, 1, 1);
                push(8'hB0, 1, 16'h0017, 0, 0);
                push(8'hBC, 1, 16'h0080, 0, 0);
                push(8'h3B, 1, 16'h0000, 0, 0);
                push(8'hB0, 1, 16'h0016, 0, 0);
                push(8'hB8, 2, 16'hFFF9, 0, 0);
                push(8'h11, 0, 0, 0, 0);
                push(8'h29, 0, 0, 0, 0);
            end else if (start_off && m_active) begin
                m_busy = 1; m_on = 0; m_acc = 0; m_error = 0;
                push(8'h28, 0, 0, 0, 0);
                push(8'hB8, 2, 16'h8002, 0, 0);
                push(8'h10, 0, 0, 0, 0);
                push(8'hB0, 1, 16'h0000, 0, 0);
            end
        end else if (wr_done) begin
            exp_t f;
            f = mq.pop_front();
            if (wr_err && f.fatal) begin
                m_busy = 0; m_error = 1; mq.delete();
            end else begin
                if (m_on) m_acc = m_acc | wr_err;
                if (mq.size() == 0) begin
                    m_busy = 0; m_active = m_on; m_error = m_acc;
                end
            end
        end
    end

    // writer model and per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R9 busy", busy, m_busy);
            chk(active == m_active, "R4 active", active, m_active);
            chk(error == m_error, "R5 error", error, m_error);
            if (busy && !req_valid) gap++;
            if (wr_done) begin
                wr_done = 0; wr_err = 0; lat = 0;
            end else if (req_valid) begin
                if (lat == 0 && gap_armed) chk(gap == exp_gap, "R2 wait", gap, exp_gap);
                lat++;
                if (lat >= 2) begin
                    if (mq.size() == 0) begin
                        chk(0, "R9 unexpected request", req_cmd, 0);
                    end else begin
                        chk(req_cmd == mq[0].cmd[7:0], "R4 cmd", req_cmd, mq[0].cmd);
                        chk(req_nbytes == mq[0].nb[1:0], "R4 nbytes", req_nbytes, mq[0].nb);
                        if (mq[0].nb != 0)
                            chk(req_data == mq[0].val[15:0], "R6 data", req_data, mq[0].val);
                        exp_gap = mq[0].pause ? WAIT_CYC : 0;
                    end
                    wr_done = 1;
                    wr_err = (tx_n == inj);
                    tx_n++;
                    gap = 0;
                    gap_armed = 1;
                end
            end
        end
    end

    task automatic pulse(input bit on);
        @(negedge clk);
        if (on) start_on = 1; else start_off = 1;
        @(negedge clk);
        start_on = 0; start_off = 0;
    endtask

    task automatic arm(input int e);
        @(negedge clk);
        inj = e; tx_n = 0; gap_armed = 0; gap = 0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 2000) begin @(negedge clk); t++; end
        chk(t < 2000, "R9 run ends", t, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, active, error, req_valid} == 4'b0, "R1 reset", {busy, active, error, req_valid}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk({busy, active, error, req_valid} == 4'b0, "R1 after release", {busy, active, error, req_valid}, 0);

        // R7: shutdown when already off
        arm(-1); pulse(0);
        chk(busy == 0, "R7 off ignored", busy, 0);
        repeat (2) @(negedge clk);

        // R2 R4: clean bring-up
        arm(-1); pulse(1);
        chk(busy == 1, "R9 busy after start", busy, 1);
        wait_idle();
        chk(tx_n == 10, "R4 step count", tx_n, 10);
        chk(active == 1 && error == 0, "R4 active end", {active, error}, 2);

        // R7: bring-up when already on
        arm(-1); pulse(1);
        chk(busy == 0, "R7 on ignored", busy, 0);

        // R6: shutdown with an error in step 1
        arm(1); pulse(0);
        wait_idle();
        chk(tx_n == 4, "R6 step count", tx_n, 4);
        chk(active == 0 && error == 0, "R6 end state", {active, error}, 0);

        // R3: abort in second opening command
        arm(1); pulse(1);
        wait_idle();
        chk(tx_n == 2, "R3 no further requests", tx_n, 2);
        chk(active == 0 && error == 1, "R3 end state", {active, error}, 1);

        // R5 R8 R10: later error, extra pulses while running
        arm(5); pulse(1);
        chk(error == 0, "R10 error cleared", error, 0);
        pulse(0);
        pulse(1);
        chk(busy == 1, "R8 still running", busy, 1);
        wait_idle();
        chk(tx_n == 10, "R8 list unchanged", tx_n, 10);
        chk(active == 1 && error == 1, "R5 end state", {active, error}, 3);

        // R10: shutdown clears the flag
        arm(-1); pulse(0);
        chk(error == 0 && busy == 1, "R10 cleared on shutdown", {error, busy}, 1);
        wait_idle();
        chk(active == 0, "R6 inactive", active, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule